// File: doc/BRIEF.md
# Bidirectional Eight-Pin I/O Port

This block is one I/O bank that holds eight pins. It connects to a small register bus that has a write strobe and a combinational read port. Software sets each pin's direction and the value driven on output pins. It can turn on a weak pull-up for each pin, and it can mark a pin as analog so that its digital read returns zero. The block sends three vectors to the pad ring: output enable, output data and pull-up enable. An outside input can turn off every pull-up at once.

Reads come from two addresses. The port address returns the pin levels, taken after a two-flop synchronizer. The latch address returns the value last written for output. Software should use the latch address for read-modify-write, because then an input pin's level cannot leak into the output data. Writes to either address update the output latch. After power-on reset the analog selection for pins 4 down to 0 depends on a boot strap. When the strap is low those pins come up analog. When it is high they come up digital.

Top module: `gpio_bank`

## Requirements
- R1: The direction register is at address 2. A bit of 1 makes its pin an input and holds `padOe` low for that pin. A bit of 0 raises `padOe` for that pin, and `padOut` carries the latch bit.
- R2: A write to address 1 loads the output latch, which appears on `padOut` one cycle later. A read of address 1 returns the latch whatever the pin levels are.
- R3: Bit i of `padPullEn` is high only when all of these hold: bit i of the pull-up register (address 3) is 1, pin i is an input, and `pullGlobalOff` is 0. When `pullGlobalOff` is 1, every pull-up is off.
- R4: A pin whose direction bit is 0 never has its pull-up enabled.
- R5: After reset the direction register is all ones, the output latch is zero and the pull-up register is zero, so `padOe` and `padPullEn` are all zero.
- R6: A write to address 0 loads the output latch in the same way as a write to address 1.
- R7: A read of address 0 returns the pins after two clock edges of synchronizer delay. Any pin whose analog-select bit is 1 reads as 0.
- R8: The analog-select register is at address 4. At reset its bits 4:0 are 1 when `cfgDigitalBoot` is 0 and are 0 when `cfgDigitalBoot` is 1. Bits 7:5 are always 0 at reset.
- R9: Addresses 5 to 7 read as zero, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| cfgDigitalBoot | input | 1 | Boot strap: 1 makes pins 4:0 digital after reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| pinIn | input | 8 | Pin levels from the pads, asynchronous |
| pullGlobalOff | input | 1 | 1 turns off every pull-up |
| padOe | output | 8 | Output enable for each pin |
| padOut | output | 8 | Output data for each pin |
| padPullEn | output | 8 | Weak pull-up enable for each pin |

## Verification
Every register drives a pad output straight through gates, so a wrong direction, latch or pull-up bit is visible on `padOe`, `padOut` or `padPullEn` in the cycle after the write. A fault in the synchronizer or the analog mask shows only on a port-address read. It is visible on the second edge after a pin changes, and a stage that is missing or added shows as data one edge early or late. The reset value of the analog register is visible by reading address 4 right after reset, once with each strap level.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PORT = 3'd0;
  localparam logic [ADDR_W-1:0] A_LAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PUE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ANA  = 3'd4;

  typedef enum logic [2:0] {
    RD_PORT, RD_LAT, RD_DIR, RD_PUE, RD_ANA, RD_NONE
  } rdsel_e;

  typedef struct packed {
    logic   wrLat;
    logic   wrDir;
    logic   wrPue;
    logic   wrAna;
    rdsel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobes_t          strb
);
  always_comb begin
    strb.wrLat = busWrEn && (busAddr == A_PORT || busAddr == A_LAT);
    strb.wrDir = busWrEn && (busAddr == A_DIR);
    strb.wrPue = busWrEn && (busAddr == A_PUE);
    strb.wrAna = busWrEn && (busAddr == A_ANA);
    case (busAddr)
      A_PORT:  strb.rdSel = RD_PORT;
      A_LAT:   strb.rdSel = RD_LAT;
      A_DIR:   strb.rdSel = RD_DIR;
      A_PUE:   strb.rdSel = RD_PUE;
      A_ANA:   strb.rdSel = RD_ANA;
      default: strb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] ANA_RST = 8'h1F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDigitalBoot,
  input  strobes_t         strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic             pullGlobalOff,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullEn
);
  localparam logic [WIDTH-1:0] ALL_IN = {WIDTH{1'b1}};

  logic [WIDTH-1:0] dirReg, latReg, pueReg, anaReg;
  logic [WIDTH-1:0] syncMeta, syncPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= ALL_IN;
      latReg <= '0;
      pueReg <= '0;
      anaReg <= cfgDigitalBoot ? '0 : ANA_RST;
    end else begin
      if (strb.wrDir) dirReg <= wrData;
      if (strb.wrLat) latReg <= wrData;
      if (strb.wrPue) pueReg <= wrData;
      if (strb.wrAna) anaReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= '0;
      syncPin  <= '0;
    end else begin
      syncMeta <= pinIn;
      syncPin  <= syncMeta;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign padOe[i]     = ~dirReg[i];
    assign padOut[i]    = latReg[i];
    assign padPullEn[i] = pueReg[i] & dirReg[i] & ~pullGlobalOff;
  end

  always_comb begin
    case (strb.rdSel)
      RD_PORT: rdData = syncPin & ~anaReg;
      RD_LAT:  rdData = latReg;
      RD_DIR:  rdData = dirReg;
      RD_PUE:  rdData = pueReg;
      RD_ANA:  rdData = anaReg;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] ANA_RST = 8'h1F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDigitalBoot,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic              pullGlobalOff,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padPullEn
);
  strobes_t strb;

  gpio_bank_ctrl u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strb   (strb)
  );

  gpio_bank_dp #(.WIDTH(WIDTH), .ANA_RST(ANA_RST)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cfgDigitalBoot(cfgDigitalBoot),
    .strb          (strb),
    .wrData        (busWrData),
    .pinIn         (pinIn),
    .pullGlobalOff (pullGlobalOff),
    .rdData        (busRdData),
    .padOe         (padOe),
    .padOut        (padOut),
    .padPullEn     (padPullEn)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [WIDTH-1:0]  busWrData,
  input logic [WIDTH-1:0]  busRdData,
  input logic              pullGlobalOff,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padPullEn
);
  p_dir_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == A_DIR |=> padOe == ~$past(busWrData));

  p_lat_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == A_LAT |=> padOut == $past(busWrData));

  p_lat_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == A_LAT |-> busRdData == padOut);

  p_global_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    pullGlobalOff |-> padPullEn == '0);

  p_no_pull_on_output_r4: assert property (@(posedge clk) disable iff (!rstN)
    (padPullEn & padOe) == '0);

  p_port_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == A_PORT |=> padOut == $past(busWrData));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    busAddr > A_ANA |-> busRdData == '0);

  p_unused_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr > A_ANA |=> $stable(padOe) && $stable(padOut));
endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  logic       clk = 0;
  logic       rstN = 0;
  logic       cfgDigitalBoot = 0;
  logic [2:0] busAddr = 0;
  logic       busWrEn = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] busRdData;
  logic [7:0] pinIn = 0;
  logic       pullGlobalOff = 0;
  logic [7:0] padOe, padOut, padPullEn;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rstN(rstN), .cfgDigitalBoot(cfgDigitalBoot),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .pinIn(pinIn), .pullGlobalOff(pullGlobalOff),
    .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );

  typedef struct packed {
    logic [2:0] addr;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] pins;
    logic       goff;
    logic [7:0] expRd;
    logic [7:0] expOe;
    logic [7:0] expOut;
    logic [7:0] expPu;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 8'h00, 8'hA5, 1'b0, 8'hA0, 8'h00, 8'h00, 8'h00, 4'd7}, // R7 analog bits read 0
    '{3'd4, 1'b1, 8'h00, 8'hA5, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 4'd8}, // R8 clear analog
    '{3'd0, 1'b0, 8'h00, 8'hA5, 1'b0, 8'hA5, 8'h00, 8'h00, 8'h00, 4'd7}, // R7 all digital
    '{3'd3, 1'b1, 8'hF0, 8'hA5, 1'b0, 8'hF0, 8'h00, 8'h00, 8'hF0, 4'd3}, // R3 pull-ups on inputs
    '{3'd2, 1'b1, 8'h0F, 8'hA5, 1'b0, 8'h0F, 8'hF0, 8'h00, 8'h00, 4'd4}, // R4 and R1 outputs lose pull-ups
    '{3'd1, 1'b1, 8'h3C, 8'hA5, 1'b0, 8'h3C, 8'hF0, 8'h3C, 8'h00, 4'd2}, // R2 latch write
    '{3'd1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h3C, 8'hF0, 8'h3C, 8'h00, 4'd2}, // R2 latch read ignores pins
    '{3'd0, 1'b1, 8'h96, 8'h5A, 1'b0, 8'h5A, 8'hF0, 8'h96, 8'h00, 4'd6}, // R6 port write hits latch
    '{3'd2, 1'b1, 8'hFF, 8'h5A, 1'b0, 8'hFF, 8'h00, 8'h96, 8'hF0, 4'd1}, // R1 back to inputs
    '{3'd2, 1'b0, 8'h00, 8'h5A, 1'b1, 8'hFF, 8'h00, 8'h96, 8'h00, 4'd3}, // R3 global off
    '{3'd6, 1'b1, 8'hFF, 8'h5A, 1'b1, 8'h00, 8'h00, 8'h96, 8'h00, 4'd9}, // R9 unused write
    '{3'd5, 1'b0, 8'h00, 8'h5A, 1'b0, 8'h00, 8'h00, 8'h96, 8'hF0, 4'd9}  // R9 unused read, state kept
  };

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    cfgDigitalBoot = strap;
    busWrEn = 0;
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic readAt(input logic [2:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    doReset(1'b0);
    // R5 reset state
    check("R5", "padOe", padOe, 8'h00);
    check("R5", "padOut", padOut, 8'h00);
    check("R5", "padPullEn", padPullEn, 8'h00);
    readAt(3'd2, d); check("R5", "dir", d, 8'hFF);
    readAt(3'd1, d); check("R5", "lat", d, 8'h00);
    readAt(3'd3, d); check("R5", "pue", d, 8'h00);
    // R8 strap low: pins 4:0 analog
    readAt(3'd4, d); check("R8", "ana strap0", d, 8'h1F);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busAddr = VECS[i].addr;
      busWrEn = VECS[i].wr;
      busWrData = VECS[i].wdata;
      pinIn = VECS[i].pins;
      pullGlobalOff = VECS[i].goff;
      @(negedge clk);
      busWrEn = 0;
      repeat (2) @(negedge clk);
      check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d rd", i), busRdData, VECS[i].expRd);
      check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d oe", i), padOe, VECS[i].expOe);
      check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d out", i), padOut, VECS[i].expOut);
      check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d pull", i), padPullEn, VECS[i].expPu);
    end

    // R7 synchronizer latency: two edges
    busAddr = 3'd0;
    @(negedge clk);
    pinIn = 8'hFF;
    @(negedge clk);
    check("R7", "after one edge", busRdData, 8'h5A);
    @(negedge clk);
    check("R7", "after two edges", busRdData, 8'hFF);

    // R8 strap high: all digital after reset
    doReset(1'b1);
    readAt(3'd4, d); check("R8", "ana strap1", d, 8'h00);
    readAt(3'd2, d); check("R5", "dir strap1", d, 8'hFF);
    check("R5", "padPullEn strap1", padPullEn, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule